// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Detection

This block turns asynchronous serial frames into parallel characters. An external receive clock, slower than the system clock, is brought into the system clock domain. Its rising edges are counted to time the frame at a bit rate of one, one sixteenth or one sixty-fourth of that clock. A falling edge on the idle line starts a frame. In the oversampled rates the line is tested again half a bit later, and a pulse that has already ended by then is dropped. Every later bit is sampled at its centre.

The character has 5 to 8 data bits, sent least significant bit first. An optional parity bit and a stop bit follow. When the stop bit is sampled, the character is placed right-justified on the data output and a ready flag is raised. A host reads the character and acknowledges it with a one-cycle read strobe. Parity, overrun and framing faults are kept in sticky flags, which only an error-clear pulse resets. A break indicator rises when the line is low at the stop position of two frames in a row.

Top module: `async_rx_core`

## Requirements
- R1: After reset, rxData is 0, and rxReady, parityErr, overrunErr, framingErr and breakDet are all 0.
- R2: The data bits arrive least significant bit first. charLenSel codes 0..3 select 5..8 data bits. rxData holds the character right-justified, with the unused upper bits 0. factorSel codes 0, 1 and 2 select 1, 16 and 64 receive-clock periods per bit.
- R3: At 16 and 64 clocks per bit, the line is tested again 8 or 32 receive clocks after the start edge. A low pulse that has ended by then is ignored, and the receiver goes back to waiting for a start edge. A low pulse longer than half a bit starts a frame. At 1 clock per bit, each bit is sampled on a rising edge of rxClk.
- R4: With parityEn = 1, a parity bit follows the data. parityOdd = 1 selects odd parity and 0 selects even. A mismatch in a frame whose stop bit is high sets parityErr.
- R5: rxReady goes to 1 when a frame completes and goes to 0 after a readStrobe pulse.
- R6: If a frame completes while rxReady is still 1 and not being read, overrunErr is set and rxData takes the new character.
- R7: A stop bit sampled low sets framingErr.
- R8: breakDet goes to 1 when the stop bits of two consecutive frames are both sampled low. It returns to 0 once the line is high.
- R9: A frame whose stop bit is low never sets parityErr.
- R10: parityErr, overrunErr and framingErr stay set until an errClear pulse, which clears all three.
- R11: While rxEnable is 0, no frame is received and rxReady does not rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rxLine | input | 1 | Serial input line, high when idle |
| rxClk | input | 1 | Receive clock, sampled on its rising edges |
| rxEnable | input | 1 | Receiver enable |
| errClear | input | 1 | One-cycle pulse that clears the error flags |
| readStrobe | input | 1 | One-cycle pulse that acknowledges rxData |
| factorSel | input | 2 | Clocks per bit: 0 = 1, 1 = 16, 2 or 3 = 64 |
| charLenSel | input | 2 | Data bits minus 5 |
| parityEn | input | 1 | Parity bit present |
| parityOdd | input | 1 | 1 = odd parity, 0 = even |
| rxData | output | 8 | Received character, right-justified |
| rxReady | output | 1 | A character is waiting to be read |
| parityErr | output | 1 | Sticky parity fault |
| overrunErr | output | 1 | Sticky overrun fault |
| framingErr | output | 1 | Sticky framing fault |
| breakDet | output | 1 | Break on the line |

## Verification
The bench builds the block with its default parameters: 8-bit maximum character, two synchronizer stages, and oversampling lengths of 16 and 64. A receive clock of eight system clocks keeps frames short. That makes it cheap to send all 256 byte values at one clock per bit and to sweep every character length against every parity mode at sixteen clocks per bit. It also leaves room for several frames at sixty-four clocks per bit. Start pulses just under and just over half a bit, a held-low break at odd parity, back-to-back unread frames and a disabled receiver cover the edge cases.

// File: rtl/async_rx_pkg.sv
package async_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } rx_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clearAcc;   // new frame begins
    logic shiftBit;   // sample a data bit
    logic takeParity; // sample the parity bit
    logic finish;     // sample the stop bit and deliver
  } rx_strobe_t;

endpackage

// File: rtl/async_rx_ctrl.sv
module async_rx_ctrl
  import async_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int X16_LEN = 16,
  parameter int X64_LEN = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rxEnable,
  input  logic       tick,
  input  logic       lineS,
  input  logic [1:0] factorSel,
  input  logic [1:0] charLenSel,
  input  logic       parityEn,
  output rx_strobe_t strb
);
  localparam int CNT_W   = $clog2(X64_LEN);
  localparam int IDX_W   = $clog2(DATA_W);
  localparam int MIN_LEN = DATA_W - 3;

  rx_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  bitIdx;
  logic [CNT_W-1:0]  fullReload;
  logic [CNT_W-1:0]  halfReload;
  logic [IDX_W-1:0]  lastIdx;
  logic              bitEvent;

  always_comb begin
    case (factorSel)
      2'd0:    begin fullReload = '0;                     halfReload = '0; end
      2'd1:    begin fullReload = CNT_W'(X16_LEN - 1);    halfReload = CNT_W'(X16_LEN / 2 - 1); end
      default: begin fullReload = CNT_W'(X64_LEN - 1);    halfReload = CNT_W'(X64_LEN / 2 - 1); end
    endcase
  end

  assign lastIdx  = IDX_W'(MIN_LEN - 1) + IDX_W'(charLenSel);
  assign bitEvent = tick && (cnt == '0);

  always_comb begin
    strb = '0;
    case (state)
      ST_IDLE:  strb.clearAcc   = tick && !lineS;
      ST_DATA:  strb.shiftBit   = bitEvent;
      ST_PAR:   strb.takeParity = bitEvent;
      ST_STOP:  strb.finish     = bitEvent;
      default:  ;
    endcase
    if (!rxEnable) strb = '0;
  end

  always_ff @(posedge clk) begin
    if (rst || !rxEnable) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      bitIdx <= '0;
    end else if (tick) begin
      case (state)
        ST_IDLE: if (!lineS) begin
          bitIdx <= '0;
          if (factorSel == 2'd0) begin
            state <= ST_DATA;
            cnt   <= '0;
          end else begin
            state <= ST_START;
            cnt   <= halfReload;
          end
        end
        ST_START: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (lineS) state <= ST_IDLE;
          else begin
            state <= ST_DATA;
            cnt   <= fullReload;
          end
        end
        ST_DATA: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else begin
            cnt    <= fullReload;
            bitIdx <= bitIdx + 1'b1;
            if (bitIdx == lastIdx) state <= parityEn ? ST_PAR : ST_STOP;
          end
        end
        ST_PAR: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else begin
            cnt   <= fullReload;
            state <= ST_STOP;
          end
        end
        ST_STOP: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/async_rx_datapath.sv
module async_rx_datapath
  import async_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxLine,
  input  logic              rxClk,
  input  rx_strobe_t        strb,
  input  logic [1:0]        charLenSel,
  input  logic              parityEn,
  input  logic              parityOdd,
  input  logic              readStrobe,
  input  logic              errClear,
  output logic              tick,
  output logic              lineS,
  output logic [DATA_W-1:0] rxData,
  output logic              rxReady,
  output logic              parityErr,
  output logic              overrunErr,
  output logic              framingErr,
  output logic              breakDet
);
  logic [SYNC_STAGES-1:0] lineSync;
  logic [SYNC_STAGES-1:0] clkSync;
  logic                   clkPrev;
  logic [DATA_W-1:0]      shiftReg;
  logic                   parAcc;
  logic                   lastStopLow;
  logic                   setParity, setOverrun, setFraming;

  // line and clock pass through equal-depth synchronizers
  generate
    if (SYNC_STAGES > 1) begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) begin
          lineSync <= '1;
          clkSync  <= '0;
        end else begin
          lineSync <= {lineSync[SYNC_STAGES-2:0], rxLine};
          clkSync  <= {clkSync[SYNC_STAGES-2:0], rxClk};
        end
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst) begin
          lineSync <= '1;
          clkSync  <= '0;
        end else begin
          lineSync <= rxLine;
          clkSync  <= rxClk;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) clkPrev <= 1'b0;
    else     clkPrev <= clkSync[SYNC_STAGES-1];
  end

  assign lineS = lineSync[SYNC_STAGES-1];
  assign tick  = clkSync[SYNC_STAGES-1] && !clkPrev;

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '0;
      parAcc   <= 1'b0;
    end else if (strb.clearAcc) begin
      shiftReg <= '0;
      parAcc   <= 1'b0;
    end else if (strb.shiftBit) begin
      shiftReg <= {lineS, shiftReg[DATA_W-1:1]};
      parAcc   <= parAcc ^ lineS;
    end else if (strb.takeParity) begin
      parAcc   <= parAcc ^ lineS;
    end
  end

  assign setParity  = strb.finish && lineS && parityEn && (parAcc != parityOdd);
  assign setOverrun = strb.finish && rxReady && !readStrobe;
  assign setFraming = strb.finish && !lineS;

  always_ff @(posedge clk) begin
    if (rst) begin
      rxData      <= '0;
      rxReady     <= 1'b0;
      parityErr   <= 1'b0;
      overrunErr  <= 1'b0;
      framingErr  <= 1'b0;
      breakDet    <= 1'b0;
      lastStopLow <= 1'b0;
    end else begin
      if (strb.finish) begin
        rxData      <= shiftReg >> (2'd3 - charLenSel);
        rxReady     <= 1'b1;
        lastStopLow <= !lineS;
      end else if (readStrobe) begin
        rxReady <= 1'b0;
      end
      parityErr  <= (parityErr  && !errClear) || setParity;
      overrunErr <= (overrunErr && !errClear) || setOverrun;
      framingErr <= (framingErr && !errClear) || setFraming;
      if (setFraming && lastStopLow) breakDet <= 1'b1;
      else if (lineS)                breakDet <= 1'b0;
    end
  end
endmodule

// File: rtl/async_rx_core.sv
module async_rx_core
  import async_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SYNC_STAGES = 2,
  parameter int X16_LEN = 16,
  parameter int X64_LEN = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rxLine,
  input  logic              rxClk,
  input  logic              rxEnable,
  input  logic              errClear,
  input  logic              readStrobe,
  input  logic [1:0]        factorSel,
  input  logic [1:0]        charLenSel,
  input  logic              parityEn,
  input  logic              parityOdd,
  output logic [DATA_W-1:0] rxData,
  output logic              rxReady,
  output logic              parityErr,
  output logic              overrunErr,
  output logic              framingErr,
  output logic              breakDet
);
  rx_strobe_t strb;
  logic       tick;
  logic       lineS;
  logic       doneStrobe;

  assign doneStrobe = strb.finish;

  async_rx_ctrl #(.DATA_W(DATA_W), .X16_LEN(X16_LEN), .X64_LEN(X64_LEN)) u_ctrl (
    .clk(clk), .rst(rst), .rxEnable(rxEnable), .tick(tick), .lineS(lineS),
    .factorSel(factorSel), .charLenSel(charLenSel), .parityEn(parityEn), .strb(strb)
  );

  async_rx_datapath #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rst(rst), .rxLine(rxLine), .rxClk(rxClk), .strb(strb),
    .charLenSel(charLenSel), .parityEn(parityEn), .parityOdd(parityOdd),
    .readStrobe(readStrobe), .errClear(errClear), .tick(tick), .lineS(lineS),
    .rxData(rxData), .rxReady(rxReady), .parityErr(parityErr),
    .overrunErr(overrunErr), .framingErr(framingErr), .breakDet(breakDet)
  );
endmodule

// File: rtl/async_rx_checker.sv
module async_rx_checker (
  input logic clk,
  input logic rst,
  input logic rxEnable,
  input logic readStrobe,
  input logic errClear,
  input logic rxReady,
  input logic parityErr,
  input logic overrunErr,
  input logic framingErr,
  input logic breakDet,
  input logic finish,
  input logic lineS
);
  logic [2:0] errFlags;
  assign errFlags = {parityErr, overrunErr, framingErr};

  assert_read_clears_R5: assert property (@(posedge clk) disable iff (rst)
    (readStrobe && !finish) |=> !rxReady);

  assert_overrun_set_R6: assert property (@(posedge clk) disable iff (rst)
    (finish && rxReady && !readStrobe) |=> overrunErr);

  assert_framing_set_R7: assert property (@(posedge clk) disable iff (rst)
    (finish && !lineS) |=> framingErr);

  assert_break_release_R8: assert property (@(posedge clk) disable iff (rst)
    (breakDet && lineS) |=> !breakDet);

  assert_flags_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (errFlags != 3'b000 && !errClear) |=> ((errFlags & $past(errFlags)) == $past(errFlags)));

  assert_flags_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (errClear && !finish) |=> (errFlags == 3'b000));

  assert_disabled_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !rxEnable |=> !$rose(rxReady));
endmodule

bind async_rx_core async_rx_checker u_chk (
  .clk(clk), .rst(rst), .rxEnable(rxEnable), .readStrobe(readStrobe),
  .errClear(errClear), .rxReady(rxReady), .parityErr(parityErr),
  .overrunErr(overrunErr), .framingErr(framingErr), .breakDet(breakDet),
  .finish(doneStrobe), .lineS(lineS)
);

// File: tb/tb_async_rx_core.sv
module tb_async_rx_core;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rxLine = 1'b1;
  logic       rxClk = 1'b0;
  logic       rxEnable = 1'b1;
  logic       errClear = 1'b0;
  logic       readStrobe = 1'b0;
  logic [1:0] factorSel = 2'd1;
  logic [1:0] charLenSel = 2'd3;
  logic       parityEn = 1'b0;
  logic       parityOdd = 1'b0;
  logic [7:0] rxData;
  logic       rxReady, parityErr, overrunErr, framingErr, breakDet;

  int checks = 0;
  int errors = 0;
  int facN = 16;

  async_rx_core dut (
    .clk(clk), .rst(rst), .rxLine(rxLine), .rxClk(rxClk), .rxEnable(rxEnable),
    .errClear(errClear), .readStrobe(readStrobe), .factorSel(factorSel),
    .charLenSel(charLenSel), .parityEn(parityEn), .parityOdd(parityOdd),
    .rxData(rxData), .rxReady(rxReady), .parityErr(parityErr),
    .overrunErr(overrunErr), .framingErr(framingErr), .breakDet(breakDet)
  );

  always #2 clk = ~clk;     // 250 MHz
  always #16 rxClk = ~rxClk; // eight system clocks per receive clock

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic setMode(input int fcode, input int lcode, input bit pen, input bit podd);
    @(negedge clk);
    factorSel  = 2'(fcode);
    charLenSel = 2'(lcode);
    parityEn   = pen;
    parityOdd  = podd;
    facN = (fcode == 0) ? 1 : (fcode == 1) ? 16 : 64;
  endtask

  task automatic sendBit(input logic b);
    rxLine = b;
    repeat (facN) @(negedge rxClk);
  endtask

  task automatic sendFrame(input logic [7:0] d, input bit flipPar, input logic stopVal);
    int len;
    logic p;
    len = 5 + int'(charLenSel);
    p = 1'b0;
    @(negedge rxClk);
    sendBit(1'b0);
    for (int i = 0; i < len; i++) begin
      sendBit(d[i]);
      p = p ^ d[i];
    end
    if (parityEn) sendBit((parityOdd ? ~p : p) ^ flipPar);
    sendBit(stopVal);
    sendBit(1'b1);
    @(negedge clk);
  endtask

  task automatic pulseRead();
    @(negedge clk) readStrobe = 1'b1;
    @(negedge clk) readStrobe = 1'b0;
  endtask

  task automatic pulseClear();
    @(negedge clk) errClear = 1'b1;
    @(negedge clk) errClear = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v, m;
    repeat (6) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 data", rxData, 0);
    chk("R1 ready", rxReady, 0);
    chk("R1 flags", {parityErr, overrunErr, framingErr}, 0);
    chk("R1 break", breakDet, 0);

    // R2 R4 R5: 16x sweep over lengths and parity modes
    for (int l = 0; l < 4; l++) begin
      for (int pm = 0; pm < 3; pm++) begin
        for (int k = 0; k < 2; k++) begin
          setMode(1, l, pm != 0, pm == 1);
          v = 8'(l * 37 + pm * 11 + k * 90 + 5);
          m = 8'((1 << (l + 5)) - 1);
          sendFrame(v, 1'b0, 1'b1);
          chk("R2 data x16", rxData, v & m);
          chk("R5 ready set", rxReady, 1);
          chk("R4 no parity fault", parityErr, 0);
          pulseRead();
          @(negedge clk);
          chk("R5 ready cleared", rxReady, 0);
        end
      end
    end

    // R2: all byte values at one clock per bit
    setMode(0, 3, 1'b0, 1'b0);
    for (int d = 0; d < 256; d++) begin
      sendFrame(8'(d), 1'b0, 1'b1);
      chk("R2 data x1", rxData, d);
      pulseRead();
    end
    chk("R2 no faults x1", {parityErr, overrunErr, framingErr}, 0);

    // R2 R4: 64x with even parity
    setMode(2, 3, 1'b1, 1'b0);
    sendFrame(8'h3C, 1'b0, 1'b1);
    chk("R2 data x64", rxData, 8'h3C);
    chk("R4 even ok x64", parityErr, 0);
    pulseRead();

    // R3: short low pulse at 64x ignored
    @(negedge rxClk) rxLine = 1'b0;
    repeat (20) @(negedge rxClk);
    rxLine = 1'b1;
    repeat (800) @(negedge rxClk);
    @(negedge clk);
    chk("R3 glitch x64", rxReady, 0);

    // R3: short low pulse at 16x ignored, long one starts a frame
    setMode(1, 3, 1'b0, 1'b0);
    @(negedge rxClk) rxLine = 1'b0;
    repeat (4) @(negedge rxClk);
    rxLine = 1'b1;
    repeat (200) @(negedge rxClk);
    @(negedge clk);
    chk("R3 glitch x16", rxReady, 0);
    @(negedge rxClk) rxLine = 1'b0;
    repeat (10) @(negedge rxClk);
    rxLine = 1'b1;
    repeat (200) @(negedge rxClk);
    @(negedge clk);
    chk("R3 long start ready", rxReady, 1);
    chk("R3 long start data", rxData, 8'hFF);
    pulseRead();

    // R8 R9: held low at 5 bits odd parity
    setMode(0, 0, 1'b1, 1'b1);
    @(negedge rxClk) rxLine = 1'b0;
    repeat (19) @(negedge rxClk);
    @(negedge clk);
    chk("R8 break set", breakDet, 1);
    chk("R7 break framing", framingErr, 1);
    chk("R9 no parity on break", parityErr, 0);
    @(negedge rxClk) rxLine = 1'b1;
    repeat (16) @(negedge rxClk);
    @(negedge clk);
    chk("R8 break released", breakDet, 0);
    chk("R9 parity after break", parityErr, 0);
    pulseRead();
    pulseClear();
    sendFrame(8'h15, 1'b0, 1'b1);
    chk("R9 next char data", rxData, 8'h15);
    chk("R9 next char parity", parityErr, 0);
    pulseRead();

    // R7: single low stop bit
    setMode(0, 3, 1'b0, 1'b0);
    sendFrame(8'h5A, 1'b0, 1'b0);
    chk("R7 framing set", framingErr, 1);
    chk("R7 no break", breakDet, 0);
    chk("R7 data", rxData, 8'h5A);
    pulseRead();
    pulseClear();
    @(negedge clk);
    chk("R10 clear framing", framingErr, 0);

    // R6: overrun
    sendFrame(8'h11, 1'b0, 1'b1);
    sendFrame(8'h22, 1'b0, 1'b1);
    chk("R6 overrun set", overrunErr, 1);
    chk("R6 newest data", rxData, 8'h22);
    pulseRead();
    pulseClear();
    @(negedge clk);
    chk("R10 clear overrun", overrunErr, 0);

    // R4 R10: parity fault stays until cleared
    setMode(1, 2, 1'b1, 1'b0);
    sendFrame(8'h35, 1'b1, 1'b1);
    chk("R4 parity fault", parityErr, 1);
    chk("R4 no framing", framingErr, 0);
    pulseRead();
    sendFrame(8'h35, 1'b0, 1'b1);
    chk("R10 parity sticky", parityErr, 1);
    pulseRead();
    pulseClear();
    @(negedge clk);
    chk("R10 parity cleared", parityErr, 0);

    // R11: disabled receiver
    @(negedge clk) rxEnable = 1'b0;
    sendFrame(8'h6B, 1'b0, 1'b1);
    chk("R11 no ready", rxReady, 0);
    chk("R11 no overrun", overrunErr, 0);
    @(negedge clk) rxEnable = 1'b1;
    sendFrame(8'h6B, 1'b0, 1'b1);
    chk("R11 enabled again", rxData, 8'h6B);
    chk("R11 ready again", rxReady, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule